// File: doc/BRIEF.md
# Display Bus Serial Command Transmitter

This block sits on the host side of a serial display bus. It takes a stream of bytes on a valid/ready input, each tagged with a flag that marks it as a command or as data, and shifts the bytes out to a display controller on chip select, serial clock and serial data. A static framing input selects one of three word formats. Two formats carry the command/data flag inside the serial word, so the bus needs three wires. The third format sends plain bytes and puts the flag on a separate sideband line. One shifter serves all three formats.

The serial clock comes from the system clock through a programmable half-period count, so the bus rate can be set to suit the panel. When the next byte is already queued at the end of a word, the block keeps chip select asserted across the boundary. It breaks the select only when the sideband flag has to change. An active-low panel reset output follows a control input through one register stage.

Top module: `dbi_serial_tx`

## Requirements
- R1: In framing 2'd2 (byte framing) each word is 8 bits, data bit 7 first, and the sideband output `dcx` carries the flag (1 = data, 0 = command).
- R2: In framing 2'd0 (nine-bit framing) each word is 9 bits: the flag first, then data bits 7 down to 0.
- R3: In framing 2'd1 (sixteen-bit framing) each word is 16 bits: seven zero pad bits, then the flag, then data bits 7 down to 0.
- R4: `sclk` is low whenever `cs_n` is high. `sdo` changes only while `sclk` is low, so it never changes during a high phase of `sclk`.
- R5: Each high phase of `sclk` lasts `cfg_half` system clock cycles. A `cfg_half` of 0 acts as 1.
- R6: `cs_n` falls exactly one half period before the first rising edge of `sclk`. It rises together with the falling `sclk` edge that ends the last bit of a word, and never in the middle of a word.
- R7: A byte accepted during the last bit of a word follows that word without raising `cs_n`, unless R8 applies.
- R8: In byte framing, `dcx` is valid one half period before `cs_n` falls and stays stable while `cs_n` is low. A queued byte whose flag differs from the current `dcx` makes `cs_n` rise between the two words.
- R9: `in_ready` is low at every rising `sclk` edge except the one that starts the last bit of a word.
- R10: `panel_rst_n` equals the inverse of `panel_rst_req`, delayed by one clock. It is low while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Framing select: 0 nine-bit, 1 sixteen-bit, 2 byte with sideband flag. Change only while idle |
| cfg_half | input | 8 | Serial clock half period in system cycles (0 treated as 1) |
| panel_rst_req | input | 1 | High requests the panel reset |
| in_valid | input | 1 | Input byte valid |
| in_dc | input | 1 | Flag of the input byte: 1 data, 0 command |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out, sampled by the panel on rising sclk |
| dcx | output | 1 | Sideband command/data line for byte framing |
| panel_rst_n | output | 1 | Active-low reset to the panel |

## Verification
The hardest case to reach from the ports is a word boundary that has a byte already queued. This case has to be hit twice in byte framing: once with a matching flag, where the select must stay low, and once with a different flag, where the select must break. To get there, the driver holds `in_valid` high and feeds bytes one after another, so each new byte is accepted during the last bit of the previous word. The same streaming is repeated at the shortest half period, where that last bit lasts only two system cycles. A bus monitor rebuilds every word from the rising `sclk` edges and counts the falling edges of chip select for each burst.

// File: rtl/dbi_tx_pkg.sv
package dbi_tx_pkg;
    typedef enum logic [1:0] {
        FRM_NINE    = 2'd0,
        FRM_SIXTEEN = 2'd1,
        FRM_BYTE    = 2'd2
    } frame_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_SHIFT
    } tx_state_e;
endpackage

// File: rtl/dbi_tx_framer.sv
module dbi_tx_framer
    import dbi_tx_pkg::*;
#(
    parameter int DW = 8,
    localparam int WMAX = 2 * DW,
    localparam int LW = $clog2(WMAX)
) (
    input  frame_e          mode,
    input  logic            dc,
    input  logic [DW-1:0]   data,
    output logic [WMAX-1:0] word,
    output logic [LW-1:0]   len_m1
);
    // Word is left-aligned: the first bit on the wire sits at WMAX-1.
    always_comb begin
        unique case (mode)
            FRM_NINE: begin
                word   = {dc, data, {(DW-1){1'b0}}};
                len_m1 = LW'(DW);
            end
            FRM_SIXTEEN: begin
                word   = {{(DW-1){1'b0}}, dc, data};
                len_m1 = LW'(WMAX - 1);
            end
            default: begin
                word   = {data, {DW{1'b0}}};
                len_m1 = LW'(DW - 1);
            end
        endcase
    end
endmodule

// File: rtl/dbi_tx_tick.sv
module dbi_tx_tick #(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [HW-1:0] half,
    output logic          tick
);
    logic [HW-1:0] cnt_d, cnt_q;
    logic [HW-1:0] lim;

    always_comb begin
        lim  = (half == '0) ? HW'(1) : half;
        tick = en && (cnt_q == lim - HW'(1));
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + HW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dbi_serial_tx.sv
module dbi_serial_tx
    import dbi_tx_pkg::*;
#(
    parameter int DW = 8,
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic [HW-1:0] cfg_half,
    input  logic          panel_rst_req,
    input  logic          in_valid,
    input  logic          in_dc,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          cs_n,
    output logic          sclk,
    output logic          sdo,
    output logic          dcx,
    output logic          panel_rst_n
);
    localparam int WMAX = 2 * DW;
    localparam int LW   = $clog2(WMAX);

    typedef struct packed {
        tx_state_e       st;
        logic [WMAX-1:0] sh;
        logic [LW-1:0]   cnt;
        logic            sclk;
        logic            cs_n;
        logic            dcx;
        logic            pv;
        logic            pdc;
        logic [DW-1:0]   pd;
        logic            prst_n;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st: ST_IDLE, sh: '0, cnt: '0, sclk: 1'b0, cs_n: 1'b1,
        dcx: 1'b0, pv: 1'b0, pdc: 1'b0, pd: '0, prst_n: 1'b0
    };

    regs_t d, q;
    frame_e          mode;
    logic            tick;
    logic            take;
    logic            src_dc;
    logic [DW-1:0]   src_data;
    logic [WMAX-1:0] f_word;
    logic [LW-1:0]   f_len_m1;
    logic            nxt_dc;
    logic            have_next;

    assign mode = frame_e'(cfg_mode);

    // A queued byte wins over the input; the queue is empty while idle.
    assign src_dc   = q.pv ? q.pdc : in_dc;
    assign src_data = q.pv ? q.pd  : in_data;

    dbi_tx_framer #(.DW(DW)) u_framer (
        .mode   (mode),
        .dc     (src_dc),
        .data   (src_data),
        .word   (f_word),
        .len_m1 (f_len_m1)
    );

    dbi_tx_tick #(.HW(HW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.st != ST_IDLE),
        .half  (cfg_half),
        .tick  (tick)
    );

    always_comb begin
        d         = q;
        d.prst_n  = ~panel_rst_req;
        in_ready  = (q.st == ST_IDLE) ||
                    (q.st == ST_SHIFT && q.cnt == '0 && !q.pv);
        take      = in_valid && in_ready;
        have_next = q.pv || (take && q.st == ST_SHIFT);
        nxt_dc    = src_dc;

        unique case (q.st)
            ST_IDLE: begin
                if (take) begin
                    d.sh  = f_word;
                    d.cnt = f_len_m1;
                    if (mode == FRM_BYTE) d.dcx = in_dc;
                    d.st  = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    d.cs_n = 1'b0;
                    d.st   = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    d.sclk = 1'b1;
                    d.st   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (take) begin
                    d.pv  = 1'b1;
                    d.pdc = in_dc;
                    d.pd  = in_data;
                end
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                    end else begin
                        d.sclk = 1'b0;
                        if (q.cnt != '0) begin
                            d.sh  = {q.sh[WMAX-2:0], 1'b0};
                            d.cnt = q.cnt - LW'(1);
                        end else if (have_next) begin
                            d.sh  = f_word;
                            d.cnt = f_len_m1;
                            d.pv  = 1'b0;
                            if (mode == FRM_BYTE && nxt_dc != q.dcx) begin
                                d.cs_n = 1'b1;
                                d.dcx  = nxt_dc;
                                d.st   = ST_SETUP;
                            end
                        end else begin
                            d.sh   = '0;
                            d.cs_n = 1'b1;
                            d.st   = ST_IDLE;
                        end
                    end
                end
            end
            default: d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign cs_n        = q.cs_n;
    assign sclk        = q.sclk;
    assign sdo         = q.sh[WMAX-1];
    assign dcx         = q.dcx;
    assign panel_rst_n = q.prst_n;

    // R4: clock stays low outside a selected frame
    a_r4_sclk_low_when_deselected: assert property (
        @(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);

    // R4: data line holds through every high phase of the clock
    a_r4_sdo_stable_while_high: assert property (
        @(posedge clk) disable iff (!rst_n) sclk |=> (sclk |-> $stable(sdo)));

    // R6: select only rises on the clock edge that closes a bit
    a_r6_cs_rise_with_sclk_fall: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> $fell(sclk));

    // R8: sideband flag never moves while the panel is selected
    a_r8_dcx_stable_in_frame: assert property (
        @(posedge clk) disable iff (!rst_n) !cs_n |=> (!cs_n |-> $stable(dcx)));

    // R9: a queued byte blocks further intake
    a_r9_no_intake_when_queued: assert property (
        @(posedge clk) disable iff (!rst_n) q.pv |-> !in_ready);
endmodule

// File: tb/dbi_serial_tx_test.sv
`timescale 1ns/100ps
module dbi_serial_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [7:0] cfg_half = 8'd2;
    logic       panel_rst_req = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_dc = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, cs_n, sclk, sdo, dcx, panel_rst_n;

    always #2.5 clk = ~clk;

    dbi_serial_tx uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_half(cfg_half),
        .panel_rst_req(panel_rst_req), .in_valid(in_valid), .in_dc(in_dc),
        .in_data(in_data), .in_ready(in_ready), .cs_n(cs_n), .sclk(sclk),
        .sdo(sdo), .dcx(dcx), .panel_rst_n(panel_rst_n)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // vector: {mode[1:0], dc, data[7:0], half[3:0], expected word[15:0]}
    localparam int NV = 8;
    localparam logic [30:0] VEC [NV] = '{
        {2'd0, 1'b0, 8'hA5, 4'd2, 16'h00A5},
        {2'd0, 1'b1, 8'h3C, 4'd1, 16'h013C},
        {2'd1, 1'b1, 8'h81, 4'd3, 16'h0181},
        {2'd1, 1'b0, 8'hFF, 4'd2, 16'h00FF},
        {2'd2, 1'b0, 8'h2A, 4'd2, 16'h002A},
        {2'd2, 1'b1, 8'hD6, 4'd4, 16'h00D6},
        {2'd2, 1'b1, 8'h00, 4'd0, 16'h0000},
        {2'd0, 1'b1, 8'hFF, 4'd5, 16'h01FF}
    };

    // bus monitor, sampled on the falling system clock edge
    logic [15:0] cap_w [32];
    logic        cap_d [32];
    int   ncap = 0, cs_falls = 0;
    logic [15:0] mon_sh = '0;
    int   mon_bits = 0, lead = 0, hi = 0;
    bit   first_rise = 0, prev_sclk = 0, prev_cs = 1;
    logic dc_at_cs = 0;

    function automatic int cur_len();
        return (cfg_mode == 2'd0) ? 9 : (cfg_mode == 2'd1) ? 16 : 8;
    endfunction
    function automatic int cur_half();
        return (cfg_half == 0) ? 1 : int'(cfg_half);
    endfunction

    always @(negedge clk) if (rst_n) begin
        if (!cs_n && prev_cs) begin
            cs_falls++; dc_at_cs = dcx; lead = 0; first_rise = 1; mon_sh = '0;
        end
        if (!cs_n && !sclk && first_rise) lead++;
        if (sclk) hi++;
        else if (prev_sclk) begin
            chk(hi == cur_half(), "R5 high phase", hi, cur_half());
            hi = 0;
        end
        if (!cs_n && sclk && !prev_sclk) begin
            mon_sh = {mon_sh[14:0], sdo};
            mon_bits++;
            if (first_rise) begin
                chk(lead == cur_half(), "R6 select lead", lead, cur_half());
                first_rise = 0;
            end
            if (cfg_mode == 2'd2)
                chk(dcx == dc_at_cs, "R8 dcx stable", dcx, dc_at_cs);
            if (mon_bits == cur_len()) begin
                if (ncap < 32) begin cap_w[ncap] = mon_sh; cap_d[ncap] = dc_at_cs; end
                ncap++; mon_bits = 0; mon_sh = '0;
            end else begin
                chk(!in_ready, "R9 ready low mid-word", in_ready, 0);
            end
        end
        if (cs_n && !prev_cs)
            chk(mon_bits == 0, "R6 select rise at word end", mon_bits, 0);
        if (cs_n) chk(!sclk, "R4 sclk idle low", sclk, 0);
        prev_sclk = sclk; prev_cs = cs_n;
    end

    task automatic send(input logic dc, input logic [7:0] data);
        in_valid = 1'b1; in_dc = dc; in_data = data;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(in_ready && cs_n)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic burst(input int n, input logic [7:0] dcs, input logic [7:0] base,
                         input int exp_falls, input string req);
        int f0 = cs_falls, c0 = ncap;
        for (int i = 0; i < n; i++) send(dcs[i], base + 8'(i));
        wait_idle();
        chk(cs_falls - f0 == exp_falls, req, cs_falls - f0, exp_falls);
        chk(ncap - c0 == n, {req, " word count"}, ncap - c0, n);
        for (int i = 0; i < n; i++) begin
            logic [15:0] e = (cfg_mode == 2'd0) ? {7'b0, dcs[i], base + 8'(i)} :
                             (cfg_mode == 2'd1) ? {7'b0, dcs[i], base + 8'(i)} :
                                                  {8'b0, base + 8'(i)};
            chk(cap_w[c0+i] == e, {req, " word"}, cap_w[c0+i], e);
            if (cfg_mode == 2'd2)
                chk(cap_d[c0+i] == dcs[i], "R1 dcx flag", cap_d[c0+i], dcs[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R4 reset cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R4 reset sclk", sclk, 0);
        chk(panel_rst_n == 1'b0, "R10 reset panel_rst_n", panel_rst_n, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            int c0, f0;
            logic [15:0] e;
            cfg_mode = VEC[v][30:29];
            cfg_half = {4'd0, VEC[v][19:16]};
            e = VEC[v][15:0];
            c0 = ncap; f0 = cs_falls;
            @(negedge clk);
            send(VEC[v][28], VEC[v][27:20]);
            wait_idle();
            chk(ncap == c0 + 1, "R6 one word", ncap - c0, 1);
            chk(cs_falls == f0 + 1, "R6 one frame", cs_falls - f0, 1);
            if (cfg_mode == 2'd0) chk(cap_w[c0] == e, "R2 nine-bit word", cap_w[c0], e);
            if (cfg_mode == 2'd1) chk(cap_w[c0] == e, "R3 sixteen-bit word", cap_w[c0], e);
            if (cfg_mode == 2'd2) begin
                chk(cap_w[c0] == e, "R1 byte word", cap_w[c0], e);
                chk(cap_d[c0] == VEC[v][28], "R1 dcx flag", cap_d[c0], VEC[v][28]);
            end
        end

        // R7: streamed bytes share one select in the embedded-flag framings
        cfg_mode = 2'd1; cfg_half = 8'd2;
        burst(3, 8'b101, 8'h40, 1, "R7 sixteen-bit chain");
        cfg_mode = 2'd0; cfg_half = 8'd1;
        burst(3, 8'b010, 8'h70, 1, "R7 nine-bit chain fast");
        // R8: byte framing keeps select only while the flag matches
        cfg_mode = 2'd2; cfg_half = 8'd2;
        burst(2, 8'b11, 8'h10, 1, "R7 byte chain same flag");
        burst(2, 8'b10, 8'h20, 2, "R8 byte flag change breaks select");
        cfg_half = 8'd1;
        burst(3, 8'b001, 8'h90, 2, "R8 flag change fast");

        // R10: panel reset follows the request one cycle later
        panel_rst_req = 1'b1;
        @(negedge clk);
        chk(panel_rst_n == 1'b0, "R10 panel reset asserted", panel_rst_n, 0);
        panel_rst_req = 1'b0;
        @(negedge clk);
        chk(panel_rst_n == 1'b1, "R10 panel reset released", panel_rst_n, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule